// File: doc/BRIEF.md
# Prioritised Two-Class Interrupt Controller

This block gathers 32 interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. Each line is configured through a 32-bit word-only register interface with a 5-bit priority, a choice of edge or level sensing, and a class (normal or fast). A pending latch records each sensed line. A mask register keeps lines out of arbitration. A priority resolver per class picks the winning unmasked pending line.

Each class has an arm flag. While armed, the first cycle in which the class has an eligible line captures the winner's number into a source register, raises the class output and disarms the flag. The output and the captured number then hold until software writes the matching control bit. That write lowers the output, rearms the flag, and arbitration runs again on the next cycle. Reading a source register returns the captured line number and, for an edge line, also clears that line's pending bit. Software can also set a pending bit by writing the trigger register.

Top module: `intc_core`

## Requirements
- R1: After reset both outputs are low, pending and all line configuration words read 0, both source registers read 0 and the mask reads 0xFFFFFFFF.
- R2: For an edge line (configuration bit 1 = 0), the pending bit sets only when its input goes from 0 to 1. An input that stays at 1 does not set the bit again after it has been cleared.
- R3: For a level line (configuration bit 1 = 1), the pending bit sets while the input is 1 and clears when the input falls from 1 to 0.
- R4: A write to the pending register (offset 0x00) ANDs the pending bits with the write data. It does not clear a level line whose input is still 1.
- R5: Among the eligible lines of a class, the one with the smallest priority value (configuration bits [6:2]) wins. On equal priority, the higher line number wins.
- R6: A line is eligible for the fast output when configuration bit 0 is 1 and for the normal output when it is 0. A line whose mask bit (offset 0x04) is 1 is not eligible. A mask write that clears bits lets waiting lines raise the output.
- R7: Once a class output is high, it stays high and its source register keeps its value until that class is acknowledged, even if a higher-priority line becomes pending.
- R8: A control write (offset 0x18) with bit 0 set lowers the normal output and rearms it; bit 1 does the same for the fast output. If a line is eligible, the output rises again one cycle later with the new winner.
- R9: A read of the normal (0x10) or fast (0x14) source register returns the captured line number. The read clears that line's pending bit only if the line is edge-sensitive.
- R10: A write to the trigger register (0x9C) sets the pending bit of only the lowest-numbered set bit of the data. A read of it returns 0.
- R11: The configuration word of line i sits at 0x1C + 4*i and reads back its 7 stored bits, with the upper bits reading 0. The mask reads back as written.
- R12: Reads of the control register, of unmapped or unaligned offsets return 0. Writes to unmapped offsets and to the source registers change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | 32 | Interrupt lines, synchronous to clk |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_norm_o | output | 1 | Normal-class request to the processor |
| irq_fast_o | output | 1 | Fast-class request to the processor |

## Verification
The assertions take for granted that irq_in is already synchronous to clk. They also assume that every register access is a single-cycle strobe whose address and data are stable across the sampling edge, because the hold and acknowledge properties decode the control write straight from the bus pins. The bench drives every input on the falling edge and issues one access at a time with an idle cycle between accesses. It changes lines only while no access to the pending or source registers is under way, so each pending update has a single cause.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LINES   = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned PRIO_W  = 5;
  localparam int unsigned ID_W    = $clog2(LINES);
  localparam int unsigned CLASSES = 2;

  localparam logic [ADDR_W-1:0] A_PEND     = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK     = 8'h04;
  localparam logic [ADDR_W-1:0] A_SRC_NORM = 8'h10;
  localparam logic [ADDR_W-1:0] A_SRC_FAST = 8'h14;
  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h18;
  localparam logic [ADDR_W-1:0] A_CFG_BASE = 8'h1C;
  localparam logic [ADDR_W-1:0] A_SWTRIG   = 8'h9C;

  // Field order is visible to software: prio [6:2], level [1], fast [0]
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              fast;
  } line_cfg_t;

  localparam int unsigned CFG_W = $bits(line_cfg_t);
endpackage

// File: rtl/intc_line_sense.sv
module intc_line_sense #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  input  logic [N-1:0] level_mode,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] rd_ack_clr,
  input  logic         and_we,
  input  logic [N-1:0] and_data,
  output logic [N-1:0] pending
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall, wr_clr, set_i, clr_i;
    assign rise   = line_in[i] & ~prev_q[i];
    assign fall   = ~line_in[i] & prev_q[i];
    // a level line that is still driven keeps its bit against a software clear
    assign wr_clr = and_we & ~and_data[i] & ~(level_mode[i] & line_in[i]);
    assign set_i  = sw_set[i] | (level_mode[i] ? line_in[i] : rise);
    assign clr_i  = wr_clr | (rd_ack_clr[i] & ~level_mode[i]) | (level_mode[i] & fall);
    assign pend_d[i] = (pending[i] & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pending <= '0;
    end else begin
      prev_q  <= line_in;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned PW = 5,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 hit,
  output logic [IW-1:0]        win
);
  logic [PW-1:0] best;

  // ascending scan with <= : equal priority resolves to the higher line
  always_comb begin
    best = '1;
    win  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req[i] && (prio[i] <= best)) begin
        best = prio[i];
        win  = IW'(i);
      end
    end
    hit = |req;
  end
endmodule

// File: rtl/intc_arb_chan.sv
module intc_arb_chan #(
  parameter int unsigned IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rearm,
  input  logic          hit,
  input  logic [IW-1:0] win,
  output logic          irq,
  output logic [IW-1:0] src
);
  logic armed_q, armed_d, irq_d, cap_en;

  always_comb begin
    cap_en  = armed_q & hit & ~rearm;
    armed_d = armed_q;
    irq_d   = irq;
    if (rearm) begin
      armed_d = 1'b1;
      irq_d   = 1'b0;
    end else if (cap_en) begin
      armed_d = 1'b0;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq     <= 1'b0;
      src     <= '0;
    end else begin
      armed_q <= armed_d;
      irq     <= irq_d;
      if (cap_en) src <= win;
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  logic wr_en, rd_en;
  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  line_cfg_t [LINES-1:0]             cfg_q, cfg_d;
  logic      [LINES-1:0]             mask_q, mask_d;
  logic      [LINES-1:0]             level_vec, fast_vec, pending, sw_set, ack_clr;
  logic      [LINES-1:0][PRIO_W-1:0] prio_vec;
  logic      [LINES-1:0]             wlo;

  // per-line configuration words
  for (genvar i = 0; i < LINES; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_CFG_BASE) + 4 * i);
    assign cfg_d[i]     = (wr_en && bus_addr == MY_ADDR) ? line_cfg_t'(bus_wdata[CFG_W-1:0])
                                                        : cfg_q[i];
    assign level_vec[i] = cfg_q[i].level;
    assign fast_vec[i]  = cfg_q[i].fast;
    assign prio_vec[i]  = cfg_q[i].prio;
  end

  assign mask_d = (wr_en && bus_addr == A_MASK) ? bus_wdata[LINES-1:0] : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '1;
    end else begin
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
    end
  end

  // software trigger keeps only the lowest set bit
  assign wlo    = bus_wdata[LINES-1:0];
  assign sw_set = (wr_en && bus_addr == A_SWTRIG) ? (wlo & (~wlo + 1'b1)) : '0;

  intc_line_sense #(.N(LINES)) u_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (irq_in),
    .level_mode (level_vec),
    .sw_set     (sw_set),
    .rd_ack_clr (ack_clr),
    .and_we     (wr_en && bus_addr == A_PEND),
    .and_data   (bus_wdata[LINES-1:0]),
    .pending    (pending)
  );

  logic [CLASSES-1:0][LINES-1:0] elig, clr_vec;
  logic [CLASSES-1:0]            hit, irq_v, rearm;
  logic [CLASSES-1:0][ID_W-1:0]  win, src;

  for (genvar c = 0; c < CLASSES; c++) begin : g_cls
    localparam logic [ADDR_W-1:0] SRC_A = (c == 0) ? A_SRC_NORM : A_SRC_FAST;
    assign elig[c]    = pending & ~mask_q & ((c == 0) ? ~fast_vec : fast_vec);
    assign rearm[c]   = wr_en && (bus_addr == A_CTRL) && bus_wdata[c];
    assign clr_vec[c] = (rd_en && bus_addr == SRC_A) ? (LINES'(1) << src[c]) : '0;

    intc_prio_pick #(.N(LINES), .PW(PRIO_W), .IW(ID_W)) u_pick (
      .req  (elig[c]),
      .prio (prio_vec),
      .hit  (hit[c]),
      .win  (win[c])
    );

    intc_arb_chan #(.IW(ID_W)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .rearm (rearm[c]),
      .hit   (hit[c]),
      .win   (win[c]),
      .irq   (irq_v[c]),
      .src   (src[c])
    );
  end

  assign ack_clr    = clr_vec[0] | clr_vec[1];
  assign irq_norm_o = irq_v[0];
  assign irq_fast_o = irq_v[1];

  always_comb begin
    case (bus_addr)
      A_PEND:     bus_rdata = DATA_W'(pending);
      A_MASK:     bus_rdata = DATA_W'(mask_q);
      A_SRC_NORM: bus_rdata = DATA_W'(src[0]);
      A_SRC_FAST: bus_rdata = DATA_W'(src[1]);
      default:    bus_rdata = '0;
    endcase
    for (int i = 0; i < int'(LINES); i++) begin
      if (bus_addr == ADDR_W'(int'(A_CFG_BASE) + 4 * i)) bus_rdata = DATA_W'(cfg_q[i]);
    end
  end
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [LINES-1:0]   irq_in,
  input logic               irq_norm_o,
  input logic               irq_fast_o,
  input logic [ID_W-1:0]    src_norm,
  input logic [ID_W-1:0]    src_fast,
  input logic [CLASSES-1:0] hit,
  input logic [LINES-1:0]   sw_set,
  input logic [LINES-1:0]   pending,
  input logic [LINES-1:0]   level_vec
);
  logic ack_n, ack_f;
  assign ack_n = bus_sel && bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
  assign ack_f = bus_sel && bus_wr && (bus_addr == A_CTRL) && bus_wdata[1];

  p_hold_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_norm_o && !ack_n) |=> irq_norm_o);
  p_hold_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fast_o && !ack_f) |=> irq_fast_o);
  p_src_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_norm_o && !ack_n) |=> $stable(src_norm));
  p_srcf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fast_o && !ack_f) |=> $stable(src_fast));
  p_ack_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_n |=> !irq_norm_o);
  p_ack_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_f |=> !irq_fast_o);
  p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_norm_o) |-> $past(hit[0]));
  p_rise_causef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_fast_o) |-> $past(hit[1]));
  p_sw_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_set));
  p_level_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(level_vec & irq_in) & ~pending) == '0));
endmodule

bind intc_core intc_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_in    (irq_in),
  .irq_norm_o(irq_norm_o),
  .irq_fast_o(irq_fast_o),
  .src_norm  (src[0]),
  .src_fast  (src[1]),
  .hit       (hit),
  .sw_set    (sw_set),
  .pending   (pending),
  .level_vec (level_vec)
);

// File: tb/tb_intc_core.sv
`timescale 1ns/1ps
module tb_intc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_norm_o, irq_fast_o;

  always #2.5 clk = ~clk;

  intc_core dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  localparam logic [7:0] PEND = 8'h00, MASK = 8'h04, SRCN = 8'h10, SRCF = 8'h14;
  localparam logic [7:0] CTRL = 8'h18, SWT = 8'h9C;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [4:0]  bprio [32];
  logic [31:0] rv, seed, pat, keep;

  function automatic logic [7:0] cfga(input int i);
    return 8'(28 + 4 * i);
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  // highest line first, strictly smaller priority replaces
  function automatic int exp_win(input logic [31:0] p);
    int best = 32, w = -1;
    for (int i = 31; i >= 0; i--)
      if (p[i] && int'(bprio[i]) < best) begin best = int'(bprio[i]); w = i; end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    chk("R1 norm", 32'(irq_norm_o), 0);
    chk("R1 fast", 32'(irq_fast_o), 0);
    brd(PEND, rv); chk("R1 pend", rv, 0);
    brd(MASK, rv); chk("R1 mask", rv, 32'hFFFF_FFFF);
    brd(SRCN, rv); chk("R1 srcn", rv, 0);
    brd(SRCF, rv); chk("R1 srcf", rv, 0);
    for (int i = 0; i < 32; i++) begin brd(cfga(i), rv); chk("R1 cfg", rv, 0); end

    // R2 / R9 edge sweep over every line
    bwr(MASK, 0);
    for (int i = 0; i < 32; i++) begin
      irq_in = 32'(1) << i; idle(3);
      brd(PEND, rv); chk("R2 edge set", rv, 32'(1) << i);
      chk("R2 norm raised", 32'(irq_norm_o), 1);
      brd(SRCN, rv); chk("R9 source", rv, 32'(i));
      brd(PEND, rv); chk("R9 edge cleared", rv, 0);
      idle(2);
      brd(PEND, rv); chk("R2 held high no reset", rv, 0);
      bwr(CTRL, 1); idle(2);
      chk("R8 low after ack", 32'(irq_norm_o), 0);
      irq_in = '0; idle(1);
    end

    // R5 priority sweep
    seed = 32'h1357_9BDF;
    for (int t = 0; t < 12; t++) begin
      if (t == 0) begin pat = 32'hFFFF_FFFF; for (int i = 0; i < 32; i++) bprio[i] = 5'd7; end
      else if (t == 1) begin pat = 32'h5; for (int i = 0; i < 32; i++) bprio[i] = 5'd3; end
      else begin
        seed = xs(seed); pat = seed | (32'(1) << t);
        for (int i = 0; i < 32; i++) begin seed = xs(seed); bprio[i] = seed[4:0]; end
      end
      for (int i = 0; i < 32; i++) bwr(cfga(i), 32'(bprio[i]) << 2);
      irq_in = pat; idle(3);
      chk("R5 raised", 32'(irq_norm_o), 1);
      brd(SRCN, rv); chk("R5 winner", rv, 32'(exp_win(pat)));
      bwr(PEND, 0); irq_in = '0; bwr(CTRL, 1); idle(2);
    end
    for (int i = 0; i < 32; i++) bwr(cfga(i), 0);

    // R6 class split and masking
    bwr(cfga(7), 1);
    irq_in = (32'(1) << 7) | (32'(1) << 9); idle(3);
    chk("R6 fast raised", 32'(irq_fast_o), 1);
    chk("R6 norm raised", 32'(irq_norm_o), 1);
    brd(SRCF, rv); chk("R6 fast src", rv, 7);
    brd(SRCN, rv); chk("R6 norm src", rv, 9);
    irq_in = '0; bwr(PEND, 0); bwr(CTRL, 3); bwr(cfga(7), 0); idle(2);
    chk("R8 both low", 32'({irq_fast_o, irq_norm_o}), 0);
    bwr(MASK, 32'(1) << 9); irq_in = 32'(1) << 9; idle(3);
    chk("R6 masked stays low", 32'(irq_norm_o), 0);
    chk("R6 fast unaffected", 32'(irq_fast_o), 0);
    brd(PEND, rv); chk("R6 masked pending", rv, 32'(1) << 9);
    bwr(MASK, 0); idle(2);
    chk("R6 unmask raises", 32'(irq_norm_o), 1);
    brd(SRCN, rv); chk("R6 unmask src", rv, 9);
    irq_in = '0; bwr(PEND, 0); bwr(CTRL, 1); idle(2);

    // R7 / R8 hold and re-evaluate
    bwr(cfga(2), 32'd10 << 2);
    irq_in = 32'(1) << 2; idle(3);
    chk("R7 raised", 32'(irq_norm_o), 1);
    irq_in = irq_in | (32'(1) << 4); idle(3);
    brd(SRCN, rv); chk("R7 src held", rv, 2);
    chk("R7 still high", 32'(irq_norm_o), 1);
    bwr(CTRL, 1);
    chk("R8 dropped", 32'(irq_norm_o), 0);
    idle(1);
    chk("R8 re-raised", 32'(irq_norm_o), 1);
    brd(SRCN, rv); chk("R8 new winner", rv, 4);
    irq_in = '0; bwr(PEND, 0); bwr(CTRL, 1); bwr(cfga(2), 0); idle(2);

    // R3 / R4 / R9 level line
    bwr(cfga(5), 2);
    irq_in = 32'(1) << 5; idle(3);
    brd(PEND, rv); chk("R3 level set", rv, 32'(1) << 5);
    brd(SRCN, rv); chk("R9 level src", rv, 5);
    brd(PEND, rv); chk("R9 level kept", rv, 32'(1) << 5);
    bwr(PEND, 0);
    brd(PEND, rv); chk("R4 level protected", rv, 32'(1) << 5);
    irq_in = '0; idle(2);
    brd(PEND, rv); chk("R3 level clear on fall", rv, 0);
    bwr(CTRL, 1); idle(2);

    // R4 edge line AND write
    irq_in = 32'(1) << 3; idle(3);
    bwr(PEND, 32'hFFFF_FFFF);
    brd(PEND, rv); chk("R4 and ones", rv, 32'(1) << 3);
    bwr(PEND, ~(32'(1) << 3));
    brd(PEND, rv); chk("R4 and clear", rv, 0);
    irq_in = '0; bwr(CTRL, 1); idle(2);

    // R10 software trigger
    bwr(MASK, 32'hFFFF_FFFF);
    bwr(SWT, 32'h0000_00A0);
    brd(PEND, rv); chk("R10 lowest only", rv, 32'(1) << 5);
    brd(SWT, rv); chk("R10 reads zero", rv, 0);
    bwr(SWT, 0);
    brd(PEND, rv); chk("R10 zero write", rv, 32'(1) << 5);
    bwr(PEND, 0);
    bwr(SWT, 32'h8000_0000);
    brd(PEND, rv); chk("R10 top bit", rv, 32'h8000_0000);
    bwr(PEND, 0); bwr(cfga(5), 0);

    // R11 readback
    bwr(cfga(12), 32'hFFFF_FFFF);
    brd(cfga(12), rv); chk("R11 cfg all", rv, 32'h7F);
    bwr(cfga(12), 32'h55);
    brd(cfga(12), rv); chk("R11 cfg fields", rv, 32'h55);
    bwr(cfga(12), 0);
    bwr(MASK, 32'h1234_5678);
    brd(MASK, rv); chk("R11 mask", rv, 32'h1234_5678);

    // R12 unmapped, control and source writes
    brd(CTRL, rv); chk("R12 ctrl reads zero", rv, 0);
    brd(8'h08, rv); chk("R12 hole", rv, 0);
    bwr(8'h0C, 32'hDEAD_BEEF);
    brd(8'h0C, rv); chk("R12 hole write", rv, 0);
    brd(MASK, rv); chk("R12 mask untouched", rv, 32'h1234_5678);
    brd(8'hA0, rv); chk("R12 beyond map", rv, 0);
    brd(8'h1D, rv); chk("R12 unaligned", rv, 0);
    bwr(8'h1D, 32'hFFFF_FFFF);
    brd(cfga(0), rv); chk("R12 unaligned write", rv, 0);
    brd(SRCN, keep);
    bwr(SRCN, 32'h1F);
    brd(SRCN, rv); chk("R12 src write ignored", rv, keep);
    brd(PEND, rv); chk("R12 pend untouched", rv, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule